// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block drives the processor reset line from a digital supply-status input. That input comes from an external comparator that checks the supply against the trip level. Reset is active from power-on reset. It stays active while the supply is below the trip level. It is released only after the supply has stayed above the trip level for a programmable number of clock cycles. A dip during that window restarts the count, so the full hold time is needed again once the supply recovers. A parameter selects whether the reset output is active low or active high.

The same block watches the serial-port pins for the two sequences that reprogram the trip level. The sequences use digitised flags that say the programming voltage is present on the clock pin and on the data pin.

- **Raise request.** Write protect is high and both flags are set.
- **Restore-native request.** Write protect and the clock pin are high, and only the data-pin flag is set.

In both cases chip select must be seen high, then taken low, then returned high. Each recognised request gives a single-cycle pulse on its own output when chip select rises. The trip level can only be raised by a raise request. To lower it, the system first issues a restore request and then a raise request at the new level.

The analog comparator, the programming voltage and the nonvolatile storage all sit outside the block.

Every asynchronous pin passes through a two-flop synchroniser.

The hold state machine has three states:

- **HS_LOW.** Supply below the trip level; reset is active.
- **HS_COUNT.** Supply good, hold count running; reset is active.
- **HS_RUN.** Reset released.

Its transitions are:

- LOW to COUNT when the supply is good.
- COUNT to RUN when the count reaches the last cycle of the hold time.
- COUNT or RUN to LOW whenever the supply goes bad.

The programming state machine has four states:

- **PS_WAIT.** Waits for chip select to be seen high. This is the reset state.
- **PS_IDLE.** Chip select is high.
- **PS_ARMED.** Chip select is low and a qualifying pin pattern was captured.
- **PS_ABORT.** Waits for chip select to return high.

Its transitions are:

- WAIT to IDLE when chip select is high.
- IDLE to ARMED when chip select falls with a qualifying pattern.
- IDLE to ABORT when chip select falls with any other pattern.
- ARMED to ABORT when any pattern pin changes.
- ARMED to IDLE when chip select rises with the pattern unchanged; this emits the pulse.
- ABORT to IDLE when chip select is high.

Top module: `supply_reset_ctrl`

## Requirements
- R1: Reset is active (output low when ACTIVE_LOW=1, high when ACTIVE_LOW=0) during and after power-on reset while the supply-good input is low.
- R2: Reset is released only after supply-good has been high continuously for HOLD_CYCLES clock cycles, measured after the input synchroniser. Release happens no earlier than HOLD_CYCLES cycles and no later than HOLD_CYCLES+6 cycles after the input rises.
- R3: A drop of supply-good during the hold time restarts the count from zero once the supply is good again.
- R4: A drop of supply-good while reset is released makes reset active again within 4 clock cycles.
- R5: With ACTIVE_LOW=1 the output level is the inverse of the reset condition. With ACTIVE_LOW=0 the output level equals the reset condition.
- R6: With write protect high and both programming flags high, a chip-select low-then-high pulse gives exactly one trip_set_o pulse within 6 cycles of chip select rising.
- R7: With write protect high, clock pin high, clock flag low and data flag high, a chip-select pulse gives exactly one trip_restore_o pulse.
- R8: Any other combination of write protect, clock pin and flags at the falling edge of chip select gives no pulse on either output.
- R9: If any of write protect, clock pin or the two flags changes while chip select is low, no pulse is issued for that chip-select cycle.
- R10: A chip-select rise is only accepted after a high-to-low transition of chip select that followed reset. If chip select is low when reset ends, the first rise gives no pulse.
- R11: Each request pulse lasts one cycle, and trip_set_o and trip_restore_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| supply_ok_i | input | 1 | Comparator result, 1 = supply above trip level (asynchronous) |
| cs_n_i | input | 1 | Chip select pin level, low = selected (asynchronous) |
| wp_i | input | 1 | Write protect pin level (asynchronous) |
| sck_i | input | 1 | Serial clock pin logic level (asynchronous) |
| sck_hv_i | input | 1 | Programming voltage present on serial clock pin (asynchronous) |
| si_hv_i | input | 1 | Programming voltage present on serial data pin (asynchronous) |
| rst_out_o | output | 1 | Processor reset, polarity set by ACTIVE_LOW |
| trip_set_o | output | 1 | One-cycle raise-trip request |
| trip_restore_o | output | 1 | One-cycle restore-native-trip request |

## Verification
The bench sets HOLD_CYCLES to 40 instead of the 200 ms default. This brings release, restart after a dip and exact window edges within a few hundred cycles. It builds two instances on the same pins, one with ACTIVE_LOW=1 and one with ACTIVE_LOW=0, so both polarities are compared against one expected reset condition. The programming detector gets random pin patterns, with and without mid-select changes. Directed cases cover chip select held low through reset.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

    typedef enum logic [1:0] {
        HS_LOW,
        HS_COUNT,
        HS_RUN
    } hold_state_t;

    typedef enum logic [1:0] {
        PS_WAIT,
        PS_IDLE,
        PS_ARMED,
        PS_ABORT
    } prog_state_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_SET,
        REQ_RESTORE
    } req_kind_t;

    typedef struct packed {
        logic wp;
        logic sck;
        logic sck_hv;
        logic si_hv;
    } pin_vec_t;

    function automatic req_kind_t classify(input pin_vec_t p);
        if (p.wp && p.sck_hv && p.si_hv) begin
            return REQ_SET;
        end else if (p.wp && p.sck && !p.sck_hv && p.si_hv) begin
            return REQ_RESTORE;
        end
        return REQ_NONE;
    endfunction

endpackage

// File: rtl/sr_sync2.sv
module sr_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end

        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/sr_hold_fsm.sv
module sr_hold_fsm
    import supply_reset_pkg::*;
#(
    parameter int HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_s,
    output logic rst_active_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    hold_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic rst_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_LOW:   if (ok_s) state_d = HS_COUNT;
            HS_COUNT: if (!ok_s) state_d = HS_LOW;
                      else if (cnt_q == LAST) state_d = HS_RUN;
            HS_RUN:   if (!ok_s) state_d = HS_LOW;
            default:  state_d = HS_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == HS_COUNT && ok_s) cnt_q <= cnt_q + 1'b1;
            else                             cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 1'b1;
        else        rst_q <= (state_q != HS_RUN);
    end

    assign rst_active_o = rst_q;

    p_drop_asserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_s |=> ##1 rst_q);

    p_release_needs_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_q) |-> ($past(ok_s, 1) && $past(ok_s, 2)));
endmodule

// File: rtl/sr_prog_fsm.sv
module sr_prog_fsm
    import supply_reset_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_s,
    input  pin_vec_t pins_s,
    output logic     set_o,
    output logic     restore_o
);
    prog_state_t state_q, state_d;
    pin_vec_t    held_q;
    req_kind_t   held_kind;
    logic        same;
    logic        set_q, restore_q;

    assign held_kind = classify(held_q);
    assign same      = (pins_s == held_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_WAIT:  if (cs_s) state_d = PS_IDLE;
            PS_IDLE:  if (!cs_s) state_d = (classify(pins_s) != REQ_NONE) ? PS_ARMED : PS_ABORT;
            PS_ARMED: if (!same) state_d = PS_ABORT;
                      else if (cs_s) state_d = PS_IDLE;
            PS_ABORT: if (cs_s) state_d = PS_IDLE;
            default:  state_d = PS_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_WAIT;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_IDLE && !cs_s) held_q <= pins_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q     <= 1'b0;
            restore_q <= 1'b0;
        end else begin
            set_q     <= (state_q == PS_ARMED) && cs_s && same && (held_kind == REQ_SET);
            restore_q <= (state_q == PS_ARMED) && cs_s && same && (held_kind == REQ_RESTORE);
        end
    end

    assign set_o     = set_q;
    assign restore_o = restore_q;

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_q && restore_q));

    p_set_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |=> !set_q);

    p_restore_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restore_q |=> !restore_q);

    p_pulse_on_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_q || restore_q) |-> $past(cs_s));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ARMED && !same) |=> (!set_q && !restore_q));
endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
    import supply_reset_pkg::*;
#(
    parameter int HOLD_CYCLES = 25_000_000,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic cs_n_i,
    input  logic wp_i,
    input  logic sck_i,
    input  logic sck_hv_i,
    input  logic si_hv_i,
    output logic rst_out_o,
    output logic trip_set_o,
    output logic trip_restore_o
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw, synced;
    pin_vec_t pins_s;
    logic rst_active;

    assign raw = {supply_ok_i, cs_n_i, wp_i, sck_i, sck_hv_i, si_hv_i};

    sr_sync2 #(.WIDTH(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign pins_s = '{wp: synced[3], sck: synced[2], sck_hv: synced[1], si_hv: synced[0]};

    sr_hold_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .ok_s         (synced[5]),
        .rst_active_o (rst_active)
    );

    sr_prog_fsm u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (synced[4]),
        .pins_s    (pins_s),
        .set_o     (trip_set_o),
        .restore_o (trip_restore_o)
    );

    if (ACTIVE_LOW) begin : g_low
        assign rst_out_o = ~rst_active;
    end else begin : g_high
        assign rst_out_o = rst_active;
    end
endmodule

// File: tb/supply_reset_ctrl_bench.sv
module supply_reset_ctrl_bench;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, cs_n = 1'b1, wp = 1'b0, sck = 1'b0, sck_hv = 1'b0, si_hv = 1'b0;
    logic rst_lo, set_lo, res_lo;
    logic rst_hi, set_hi, res_hi;
    int tests = 0, fails = 0;
    int set_cnt = 0, res_cnt = 0, both_cnt = 0;

    always #4 clk = ~clk;

    supply_reset_ctrl #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b1)) u_supply_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .cs_n_i(cs_n), .wp_i(wp),
        .sck_i(sck), .sck_hv_i(sck_hv), .si_hv_i(si_hv),
        .rst_out_o(rst_lo), .trip_set_o(set_lo), .trip_restore_o(res_lo));

    supply_reset_ctrl #(.HOLD_CYCLES(HOLD), .ACTIVE_LOW(1'b0)) u_supply_reset_ctrl_hi (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .cs_n_i(cs_n), .wp_i(wp),
        .sck_i(sck), .sck_hv_i(sck_hv), .si_hv_i(si_hv),
        .rst_out_o(rst_hi), .trip_set_o(set_hi), .trip_restore_o(res_hi));

    always @(negedge clk) begin
        if (set_lo) set_cnt++;
        if (res_lo) res_cnt++;
        if (set_lo && res_lo) both_cnt++;
    end

    // 0 none, 1 raise, 2 restore; vector order {wp, sck, sck_hv, si_hv}
    function automatic int exp_kind(input logic [3:0] v);
        if (v[3] && v[1] && v[0]) return 1;
        if (v[3] && v[2] && !v[1] && v[0]) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_reset(input bit exp_active, input string req);
        @(negedge clk);
        check(rst_lo == !exp_active, {req, " low-polarity"}, int'(rst_lo), int'(!exp_active));
        check(rst_hi == exp_active, {req, " high-polarity R5"}, int'(rst_hi), int'(exp_active));
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [3:0] v);
        {wp, sck, sck_hv, si_hv} = v;
    endtask

    task automatic prog_cycle(input logic [3:0] v, input bit change, input logic [3:0] v2,
                              input string req);
        int s0, r0, k;
        @(negedge clk);
        set_pins(v);
        cycles(4);
        cs_n = 1'b0;
        cycles(5);
        if (change) set_pins(v2);
        cycles(5);
        s0 = set_cnt;
        r0 = res_cnt;
        cs_n = 1'b1;
        cycles(8);
        k = (change && v2 != v) ? 0 : exp_kind(v);
        check(set_cnt - s0 == (k == 1 ? 1 : 0), {req, " set"}, set_cnt - s0, k == 1 ? 1 : 0);
        check(res_cnt - r0 == (k == 2 ? 1 : 0), {req, " restore"}, res_cnt - r0, k == 2 ? 1 : 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R10: chip select low through reset with a raise pattern
        cs_n = 1'b0;
        set_pins(4'b1011);
        cycles(3);
        check_reset(1'b1, "R1 during reset");
        rst_n = 1'b1;
        cycles(10);
        check_reset(1'b1, "R1 supply low after reset");
        begin
            int s0 = set_cnt;
            cs_n = 1'b1;
            cycles(8);
            check(set_cnt == s0, "R10 first rise ignored", set_cnt - s0, 0);
        end

        // R2: release timing window
        supply_ok = 1'b1;
        cycles(HOLD - 1);
        check_reset(1'b1, "R2 still held");
        cycles(6);
        check_reset(1'b0, "R2 released");

        // R4: drop asserts quickly
        supply_ok = 1'b0;
        cycles(3);
        check_reset(1'b1, "R4 drop");

        // R3: restart on dip
        supply_ok = 1'b1;
        cycles(HOLD / 2);
        supply_ok = 1'b0;
        cycles(5);
        supply_ok = 1'b1;
        cycles(HOLD - 1);
        check_reset(1'b1, "R3 restart");
        cycles(6);
        check_reset(1'b0, "R3 eventual release");

        // Directed programming cases
        prog_cycle(4'b1011, 1'b0, 4'b0, "R6 raise");
        prog_cycle(4'b1101, 1'b0, 4'b0, "R7 restore");
        prog_cycle(4'b0011, 1'b0, 4'b0, "R8 wp low");
        prog_cycle(4'b1001, 1'b0, 4'b0, "R8 sck low");
        prog_cycle(4'b1011, 1'b1, 4'b1010, "R9 abort raise");
        prog_cycle(4'b1101, 1'b1, 4'b0101, "R9 abort restore");

        // Random patterns, optional mid-select change
        for (int i = 0; i < 60; i++) begin
            logic [3:0] v = 4'($urandom);
            bit ch = 1'($urandom);
            logic [3:0] v2 = 4'($urandom);
            if (($urandom % 3) == 0) v = ($urandom % 2) ? 4'b1011 : 4'b1101;
            prog_cycle(v, ch, v2, "R8 R9 random");
        end
        check(both_cnt == 0, "R11 exclusive", both_cnt, 0);
        check_reset(1'b0, "R5 final polarity");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule